// File: doc/BRIEF.md
# Tone Digit Serial Readout Interface

This block is the digital output stage of a tone-digit receiver. An abstract detector supplies a 4-bit digit code, an early tone-present flag, a delayed valid-digit flag and a call-progress detect level. The block drives both steering outputs and a single serial data pin that does two jobs. While no digit is being read out, the pin follows the call-progress level, so a host can watch the cadence of call-progress tones. Once a steering output is high, the host sends acknowledge pulses and receives the digit one bit per pulse.

The acknowledge line is asynchronous. It passes through a synchronizer and an edge detector. The digit is copied into a holding register on the first acknowledge rising edge, so later changes at the detector cannot corrupt a readout that has started. A power-down input forces all outputs low. The block enters power-down only while the synchronized acknowledge level is low. It uses a synchronous active-high reset and one system clock.

Top module: `tone_digit_readout`

## Requirements
- R1: After reset, `serial_o`, `early_steer_o` and `delayed_steer_o` are low.
- R2: Outside power-down, `early_steer_o` and `delayed_steer_o` equal `det_early_i` and `det_valid_i` as they were sampled one clock earlier.
- R3: `ack_i` is synchronized through two flops and then edge-detected. Each pulse must stay high for at least two clocks and low for at least two clocks. A serial bit appears on `serial_o` three clock edges after the first edge that samples `ack_i` high.
- R4: While `det_early_i` or `det_valid_i` is high, four acknowledge pulses shift out the digit code least significant bit first, one bit per pulse, and the pin holds that bit between pulses.
- R5: The digit is captured from `det_digit_i` at the first acknowledge rising edge. Later changes of `det_digit_i` during that readout do not alter the bits that are shifted out.
- R6: After the fourth bit, further acknowledge pulses are ignored, and `serial_o` keeps showing bit 3 whatever `det_cp_i` does.
- R7: When no readout is active, `serial_o` equals `det_cp_i` as it was sampled one clock earlier.
- R8: A readout ends and `serial_o` returns to call-progress mode when both steering inputs are low, or when `det_valid_i` rises (a new digit is confirmed).
- R9: A high `pwr_down_i` enters power-down only while the synchronized acknowledge level is low. Power-down lasts while `pwr_down_i` stays high and ends on the clock after it goes low.
- R10: In power-down all three outputs are held low and any readout is cancelled.
- R11: Acknowledge pulses that arrive while both steering inputs are low have no effect. `serial_o` keeps following `det_cp_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down_i | input | 1 | Power-down request, active high, idles low |
| ack_i | input | 1 | Asynchronous acknowledge pulses from host, idles low |
| det_digit_i | input | 4 | Decoded digit code from detector |
| det_early_i | input | 1 | Tone pair present (early) |
| det_valid_i | input | 1 | Valid digit confirmed (delayed) |
| det_cp_i | input | 1 | Call-progress detect level |
| serial_o | output | 1 | Serial digit data or call-progress cadence |
| early_steer_o | output | 1 | Early steering output |
| delayed_steer_o | output | 1 | Delayed steering output |

## Verification
The bench changes `det_digit_i` in the middle of a readout. A design that samples the digit on every pulse would then shift out a mix of two codes. It sends a fifth pulse and toggles `det_cp_i` after the readout ends, which catches a counter that wraps around or a pin that drops back to call-progress mode too early. It requests power-down while acknowledge is held high, where a design without the gate would blank its outputs, and it pulses acknowledge with both steering inputs low, where a careless design would start shifting. It also re-arms a readout by raising `det_valid_i`, and it reads out the all-zero and all-one codes so that every bit position is seen at both levels.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  typedef enum logic {
    OUT_CP    = 1'b0,
    OUT_SHIFT = 1'b1
  } out_mode_e;
endpackage

// File: rtl/tdr_ack_sync.sv
module tdr_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= ack_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], ack_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;

  // R3: a detected rise traces back to ack_i high STAGES edges earlier
  assert_rise_origin_R3: assert property (@(posedge clk) disable iff (rst)
    rise_o |-> $past(ack_i, STAGES));
endmodule

// File: rtl/tdr_pwr_ctrl.sv
module tdr_pwr_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic pwr_down_i,
  input  logic ack_lvl_i,
  output logic pd_o
);
  logic pd_q;

  always_ff @(posedge clk) begin
    if (rst) pd_q <= 1'b0;
    else     pd_q <= pwr_down_i & (pd_q | ~ack_lvl_i);
  end

  assign pd_o = pd_q;

  // R9: no entry while acknowledge is high
  assert_no_entry_ack_high_R9: assert property (@(posedge clk) disable iff (rst)
    (!pd_q && ack_lvl_i) |=> !pd_q);
  // R9: exit once the request drops
  assert_exit_on_release_R9: assert property (@(posedge clk) disable iff (rst)
    !pwr_down_i |=> !pd_q);
endmodule

// File: rtl/tdr_shifter.sv
module tdr_shifter
  import tdr_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear_i,
  input  logic               rise_i,
  input  logic [DIGIT_W-1:0] digit_i,
  output logic               shifting_o,
  output logic               bit_o
);
  localparam int CNT_W = $clog2(DIGIT_W + 1);
  localparam int IDX_W = (DIGIT_W > 1) ? $clog2(DIGIT_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIGIT_W);

  logic [CNT_W-1:0]   cnt_q;
  logic [DIGIT_W-1:0] hold_q;
  logic               bit_q;
  out_mode_e          mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      hold_q <= '0;
      bit_q  <= 1'b0;
      mode_q <= OUT_CP;
    end else if (clear_i) begin
      cnt_q  <= '0;
      mode_q <= OUT_CP;
    end else if (rise_i && (cnt_q < LAST)) begin
      if (cnt_q == '0) begin
        hold_q <= digit_i;
        bit_q  <= digit_i[0];
      end else begin
        bit_q  <= hold_q[cnt_q[IDX_W-1:0]];
      end
      cnt_q  <= cnt_q + 1'b1;
      mode_q <= OUT_SHIFT;
    end
  end

  assign shifting_o = (mode_q == OUT_SHIFT);
  assign bit_o      = bit_q;

  // R6: counter never passes the digit width
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  // R4: at most one bit advance per clock
  assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
    !clear_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
  // R5: captured digit stays put once a readout has begun
  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0 && !clear_i) |=> $stable(hold_q));
endmodule

// File: rtl/tone_digit_readout.sv
module tone_digit_readout #(
  parameter int DIGIT_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pwr_down_i,
  input  logic               ack_i,
  input  logic [DIGIT_W-1:0] det_digit_i,
  input  logic               det_early_i,
  input  logic               det_valid_i,
  input  logic               det_cp_i,
  output logic               serial_o,
  output logic               early_steer_o,
  output logic               delayed_steer_o
);
  logic ack_lvl, ack_rise, pd_q;
  logic valid_prev_q, steer, new_valid, clear;
  logic shifting, shift_bit;

  tdr_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ack_i(ack_i), .level_o(ack_lvl), .rise_o(ack_rise)
  );

  tdr_pwr_ctrl u_pwr (
    .clk(clk), .rst(rst), .pwr_down_i(pwr_down_i), .ack_lvl_i(ack_lvl), .pd_o(pd_q)
  );

  assign steer     = det_early_i | det_valid_i;
  assign new_valid = det_valid_i & ~valid_prev_q;
  assign clear     = pd_q | ~steer | new_valid;

  tdr_shifter #(.DIGIT_W(DIGIT_W)) u_shift (
    .clk(clk), .rst(rst), .clear_i(clear), .rise_i(ack_rise),
    .digit_i(det_digit_i), .shifting_o(shifting), .bit_o(shift_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_prev_q    <= 1'b0;
      serial_o        <= 1'b0;
      early_steer_o   <= 1'b0;
      delayed_steer_o <= 1'b0;
    end else begin
      valid_prev_q    <= det_valid_i;
      serial_o        <= ~pd_q & (shifting ? shift_bit : det_cp_i);
      early_steer_o   <= ~pd_q & det_early_i;
      delayed_steer_o <= ~pd_q & det_valid_i;
    end
  end

  // R10: outputs blanked during power-down
  assert_pd_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    pd_q |=> (!serial_o && !early_steer_o && !delayed_steer_o));
  // R2: steering follows detector one clock late when active
  assert_steer_follow_R2: assert property (@(posedge clk) disable iff (rst)
    !pd_q |=> (early_steer_o == $past(det_early_i)) &&
              (delayed_steer_o == $past(det_valid_i)));
endmodule

// File: tb/tone_digit_readout_tb.sv
module tone_digit_readout_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwr_down_i = 1'b0;
  logic       ack_i = 1'b0;
  logic [3:0] det_digit_i = 4'd0;
  logic       det_early_i = 1'b0;
  logic       det_valid_i = 1'b0;
  logic       det_cp_i = 1'b0;
  logic       serial_o, early_steer_o, delayed_steer_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tone_digit_readout u_dut (
    .clk(clk), .rst(rst), .pwr_down_i(pwr_down_i), .ack_i(ack_i),
    .det_digit_i(det_digit_i), .det_early_i(det_early_i),
    .det_valid_i(det_valid_i), .det_cp_i(det_cp_i),
    .serial_o(serial_o), .early_steer_o(early_steer_o),
    .delayed_steer_o(delayed_steer_o)
  );

  // behavioural reference: acknowledge delay line as a queue, integers for state
  bit ackq[$];
  int m_pd, m_shift, m_n, m_hold, m_bit, m_vp, m_prev_lvl;
  int exp_ser, exp_es, exp_ds;

  always @(posedge clk) begin
    int lvl, rise, steer, newv;
    if (rst) begin
      ackq = {1'b0, 1'b0};
      m_pd = 0; m_shift = 0; m_n = 0; m_hold = 0; m_bit = 0; m_vp = 0;
      m_prev_lvl = 0; exp_ser = 0; exp_es = 0; exp_ds = 0;
    end else begin
      lvl   = ackq[1];
      rise  = (lvl == 1 && m_prev_lvl == 0);
      steer = det_early_i || det_valid_i;
      newv  = det_valid_i && !m_vp;
      exp_es  = (m_pd == 0) && det_early_i;
      exp_ds  = (m_pd == 0) && det_valid_i;
      exp_ser = (m_pd != 0) ? 0 : (m_shift != 0 ? m_bit : int'(det_cp_i));
      if (m_pd != 0 || !steer || newv) begin
        m_shift = 0; m_n = 0;
      end else if (rise && m_n < 4) begin
        if (m_n == 0) m_hold = int'(det_digit_i);
        m_bit = (m_hold >> m_n) & 1;
        m_n++;
        m_shift = 1;
      end
      m_vp = det_valid_i;
      m_pd = (pwr_down_i && (m_pd != 0 || lvl == 0)) ? 1 : 0;
      m_prev_lvl = lvl;
      void'(ackq.pop_back());
      ackq.push_front(ack_i);
    end
  end

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R4/R7 serial_o", int'(serial_o), exp_ser);
      chk("R2 early_steer_o", int'(early_steer_o), exp_es);
      chk("R2 delayed_steer_o", int'(delayed_steer_o), exp_ds);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    ack_i = 1'b1; cyc(3);
    ack_i = 1'b0; cyc(3);
  endtask

  task automatic read_digit(input int code, input int change_to);
    for (int i = 0; i < 4; i++) begin
      pulse();
      if (i == 0 && change_to >= 0) det_digit_i = change_to[3:0];
      chk("R4 bit order", int'(serial_o), (code >> i) & 1);
    end
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    cyc(20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    chk("R1 serial", int'(serial_o), 0);
    chk("R1 early", int'(early_steer_o), 0);
    chk("R1 delayed", int'(delayed_steer_o), 0);

    // R7 / R11: cadence follows cp, pulses ignored without steering
    det_cp_i = 1'b1; cyc(2);
    chk("R7 cp high", int'(serial_o), 1);
    det_cp_i = 1'b0; pulse();
    chk("R11 pulse ignored", int'(serial_o), 0);
    det_cp_i = 1'b1; cyc(2);
    chk("R11 still cp", int'(serial_o), 1);

    // R4 / R5: digit 5, changed to 10 after the first capture
    det_cp_i = 1'b0;
    det_digit_i = 4'd5; det_early_i = 1'b1; cyc(2); det_valid_i = 1'b1; cyc(2);
    chk("R2 delayed high", int'(delayed_steer_o), 1);
    read_digit(5, 10);
    // R6: fifth pulse ignored, cp toggling does not show
    det_cp_i = 1'b1; pulse();
    chk("R6 holds bit3", int'(serial_o), 0);
    // R8: steering falls, cp returns
    det_early_i = 1'b0; det_valid_i = 1'b0; cyc(3);
    chk("R8 back to cp", int'(serial_o), 1);

    // R8: new valid digit re-arms mid readout
    det_cp_i = 1'b0; det_digit_i = 4'd12; det_early_i = 1'b1; det_valid_i = 1'b1; cyc(2);
    pulse(); pulse();
    chk("R4 bit1 of 12", int'(serial_o), 0);
    det_valid_i = 1'b0; cyc(2); det_cp_i = 1'b1; det_valid_i = 1'b1; cyc(3);
    chk("R8 new valid cp", int'(serial_o), 1);
    det_cp_i = 1'b0; det_digit_i = 4'd9; cyc(2);
    read_digit(9, -1);

    // boundary codes
    det_early_i = 1'b0; det_valid_i = 1'b0; cyc(2);
    det_digit_i = 4'd0; det_early_i = 1'b1; det_valid_i = 1'b1; det_cp_i = 1'b1; cyc(2);
    read_digit(0, -1);
    det_early_i = 1'b0; det_valid_i = 1'b0; cyc(2);
    det_digit_i = 4'd15; det_early_i = 1'b1; det_valid_i = 1'b1; det_cp_i = 1'b0; cyc(2);
    read_digit(15, 3);

    // R9: power-down refused while ack high
    det_cp_i = 1'b1;
    ack_i = 1'b1; cyc(3);
    pwr_down_i = 1'b1; cyc(4);
    chk("R9 refused with ack", int'(early_steer_o), 1);
    ack_i = 1'b0; cyc(4);
    chk("R10 early low", int'(early_steer_o), 0);
    chk("R10 delayed low", int'(delayed_steer_o), 0);
    chk("R10 serial low", int'(serial_o), 0);
    pwr_down_i = 1'b0; cyc(3);
    chk("R9 resumed", int'(early_steer_o), 1);
    chk("R10 readout cancelled", int'(serial_o), 1);

    cyc(5);
    finish_run();
  end
endmodule